// File: doc/BRIEF.md
# Deferred Line Invalidation Queue with Read Barrier

This block sits between the coherence network and the local cache of one core. When another core asks for a line to be invalidated, the block takes the request, acknowledges it on the next cycle and stores the line address in a small first-in first-out queue. The queued invalidations are handed to the cache through a dedicated invalidate port whenever the cache grants that port, one line per granted cycle. Local loads never look into the queue, so a load may still hit a line whose invalidation is pending.

Two mechanisms keep the deferred work safe. First, before the core sends a new coherence message about a line, it presents that line address on a probe input. The block raises a hold flag while any queued entry carries the same address, and the message waits until that entry has been applied. Second, the core can raise a read-barrier request. The block then stalls the core until every entry that was queued when the barrier arrived has been applied to the cache. After the barrier, loads to those lines miss and fetch fresh data. Invalidations that arrive after the barrier request do not extend that barrier. A barrier issued against an empty queue finishes in the same cycle without any stall.

Top module: `invq_top`

## Requirements
- R1: After reset the queue is empty: `inv_ready` is 1, and `inv_ack`, `cache_inv_valid`, `msg_hold`, `rb_stall` and `rb_done` are all 0.
- R2: A request is accepted in any cycle where `inv_valid` and `inv_ready` are both 1, and `inv_ack` is 1 for exactly the one cycle after each accepted request and 0 otherwise.
- R3: The queue holds at most 8 entries (parameter DEPTH). While it holds 8, `inv_ready` is 0, a request is not taken and no acknowledgement follows it.
- R4: `cache_inv_valid` is 1 exactly while the queue is non-empty, and `cache_inv_addr` then shows the oldest queued address, so lines are applied in arrival order.
- R5: In a cycle with `cache_inv_valid` and `cache_inv_grant` both 1 the oldest entry is applied and removed; without the grant the head entry and its address stay unchanged.
- R6: `msg_hold` is 1 in a cycle exactly when `msg_valid` is 1 and `msg_addr` equals the address of at least one entry held in the queue at the start of that cycle.
- R7: A barrier request in a cycle where the queue is empty and no barrier is in progress gives `rb_done` = 1 in that same cycle with `rb_stall` = 0.
- R8: A barrier request against a non-empty queue drives `rb_stall` to 1 from the request cycle until the cycle in which the last entry present at the request is granted to the cache; in that cycle `rb_done` is 1 and `rb_stall` is 0.
- R9: Requests accepted at or after the barrier request cycle are not waited for by that barrier.
- R10: A barrier request raised while a barrier is already in progress has no effect on its completion cycle.
- R11: A request accepted in the same cycle that the head entry is granted is stored while the head leaves, so the occupancy is unchanged and later order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidate request from another core |
| inv_addr | input | ADDR_W | Line address of the incoming invalidate |
| inv_ready | output | 1 | Queue has room; request is taken when valid and ready |
| inv_ack | output | 1 | Acknowledgement, one cycle after each accepted request |
| cache_inv_valid | output | 1 | A queued invalidation is offered to the cache |
| cache_inv_addr | output | ADDR_W | Line address of the oldest queued invalidation |
| cache_inv_grant | input | 1 | Cache applies the offered invalidation this cycle |
| rb_req | input | 1 | Read-barrier request from the core |
| rb_stall | output | 1 | Core must stall; barrier still draining |
| rb_done | output | 1 | Barrier completes in this cycle |
| msg_valid | input | 1 | Core wants to send a coherence message about a line |
| msg_addr | input | ADDR_W | Line address of that outgoing message |
| msg_hold | output | 1 | Outgoing message must wait; the line is still queued |

## Verification
The acknowledgement is the only registered output: it is due one cycle after the accepting edge, while ready, the cache offer, the hold flag, the stall and the done pulse are all settled combinationally in the same cycle as the inputs that cause them, from state updated at the previous edge. The bench drives every input on the falling edge, waits a short delay, compares each output against a behavioural queue model, and only then lets the model advance at the rising edge, so a removal or insertion is expected to show on the ports in the cycle after its edge. Directed phases cover the empty barrier, a full queue, a barrier interleaved with new arrivals and repeated requests, and simultaneous insert and remove, followed by a long run of random traffic with a narrow address range so that probe matches are frequent.

// File: rtl/invq_pkg.sv
package invq_pkg;

    // Barrier tracker phase
    typedef enum logic {
        BR_IDLE  = 1'b0,
        BR_DRAIN = 1'b1
    } br_phase_e;

    // Next pointer in a circular buffer of arbitrary depth
    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/invq_fifo.sv
module invq_fifo
    import invq_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [ADDR_W-1:0]              push_addr,
    input  logic                           pop,
    output logic [CNT_W-1:0]               count,
    output logic [ADDR_W-1:0]              head_addr,
    output logic [DEPTH-1:0]               slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.vld[st_q.rd] = 1'b0;
            st_d.rd = PTR_W'(wrap_inc(int'(st_q.rd), DEPTH));
        end
        if (push) begin
            st_d.mem[st_q.wr] = push_addr;
            st_d.vld[st_q.wr] = 1'b1;
            st_d.wr = PTR_W'(wrap_inc(int'(st_q.wr), DEPTH));
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.cnt;
    assign head_addr = st_q.mem[st_q.rd];
    assign slot_vld  = st_q.vld;
    assign slot_addr = st_q.mem;

endmodule

// File: rtl/invq_match.sv
module invq_match #(
    parameter int ADDR_W = 26,
    parameter int DEPTH  = 8
) (
    input  logic                         probe_valid,
    input  logic [ADDR_W-1:0]            probe_addr,
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    output logic                         hit
);

    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = slot_vld[g] && (slot_addr[g] == probe_addr);
    end

    assign hit = probe_valid && (|hit_vec);

endmodule

// File: rtl/invq_barrier.sv
module invq_barrier
    import invq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb_req,
    input  logic [CNT_W-1:0] count,
    input  logic             pop,
    output logic             rb_stall,
    output logic             rb_done
);

    typedef struct packed {
        br_phase_e        phase;
        logic [CNT_W-1:0] left;
    } br_st_t;

    br_st_t st_d, st_q;

    logic             open;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] remain_after;

    always_comb begin
        st_d         = st_q;
        open         = rb_req || (st_q.phase == BR_DRAIN);
        // a new barrier counts entries queued now; a running one ignores new requests
        remain       = (st_q.phase == BR_DRAIN) ? st_q.left : count;
        remain_after = remain - CNT_W'(pop);
        rb_done      = open && (remain_after == '0);
        rb_stall     = open && !rb_done;
        if (rb_stall) begin
            st_d.phase = BR_DRAIN;
            st_d.left  = remain_after;
        end else begin
            st_d.phase = BR_IDLE;
            st_d.left  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: BR_IDLE, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/invq_top.sv
module invq_top #(
    parameter int ADDR_W = 26,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ready,
    output logic              inv_ack,
    output logic              cache_inv_valid,
    output logic [ADDR_W-1:0] cache_inv_addr,
    input  logic              cache_inv_grant,
    input  logic              rb_req,
    output logic              rb_stall,
    output logic              rb_done,
    input  logic              msg_valid,
    input  logic [ADDR_W-1:0] msg_addr,
    output logic              msg_hold
);

    typedef struct packed {
        logic ack;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0]             count;
    logic [ADDR_W-1:0]            head_addr;
    logic [DEPTH-1:0]             slot_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic                         push;
    logic                         pop;

    always_comb begin
        inv_ready       = (count != CNT_W'(DEPTH));
        push            = inv_valid && inv_ready;
        cache_inv_valid = (count != '0);
        cache_inv_addr  = head_addr;
        pop             = cache_inv_valid && cache_inv_grant;
        st_d.ack        = push;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inv_ack = st_q.ack;

    invq_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (inv_addr),
        .pop       (pop),
        .count     (count),
        .head_addr (head_addr),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr)
    );

    invq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) match_i (
        .probe_valid (msg_valid),
        .probe_addr  (msg_addr),
        .slot_vld    (slot_vld),
        .slot_addr   (slot_addr),
        .hit         (msg_hold)
    );

    invq_barrier #(.CNT_W(CNT_W)) barrier_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_req   (rb_req),
        .count    (count),
        .pop      (pop),
        .rb_stall (rb_stall),
        .rb_done  (rb_done)
    );

endmodule

// File: rtl/invq_chk.sv
module invq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_valid,
    input logic              inv_ready,
    input logic              inv_ack,
    input logic              cache_inv_valid,
    input logic [ADDR_W-1:0] cache_inv_addr,
    input logic              cache_inv_grant,
    input logic              rb_req,
    input logic              rb_stall,
    input logic              rb_done,
    input logic              msg_valid,
    input logic              msg_hold
);

    AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_ready |=> inv_ack);  // R2

    AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_ready |=> !inv_ack);  // R3

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inv_valid && !cache_inv_grant |=> cache_inv_valid && $stable(cache_inv_addr));  // R5

    AST_HOLD_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_hold |-> msg_valid && cache_inv_valid);  // R6

    AST_EMPTY_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req && !cache_inv_valid |-> rb_done && !rb_stall);  // R7

    AST_STALL_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        rb_stall |-> cache_inv_valid && !rb_done);  // R8

endmodule

bind invq_top invq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .inv_valid       (inv_valid),
    .inv_ready       (inv_ready),
    .inv_ack         (inv_ack),
    .cache_inv_valid (cache_inv_valid),
    .cache_inv_addr  (cache_inv_addr),
    .cache_inv_grant (cache_inv_grant),
    .rb_req          (rb_req),
    .rb_stall        (rb_stall),
    .rb_done         (rb_done),
    .msg_valid       (msg_valid),
    .msg_hold        (msg_hold)
);

// File: tb/invq_top_tb_top.sv
`timescale 1ns/1ps
module invq_top_tb_top;

    localparam int AW = 26;
    localparam int QD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          inv_ready;
    logic          inv_ack;
    logic          cache_inv_valid;
    logic [AW-1:0] cache_inv_addr;
    logic          cache_inv_grant = 1'b0;
    logic          rb_req = 1'b0;
    logic          rb_stall;
    logic          rb_done;
    logic          msg_valid = 1'b0;
    logic [AW-1:0] msg_addr = '0;
    logic          msg_hold;

    always #5 clk = ~clk;

    invq_top #(.ADDR_W(AW), .DEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready), .inv_ack(inv_ack),
        .cache_inv_valid(cache_inv_valid), .cache_inv_addr(cache_inv_addr),
        .cache_inv_grant(cache_inv_grant),
        .rb_req(rb_req), .rb_stall(rb_stall), .rb_done(rb_done),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_hold(msg_hold)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // behavioural model state
    logic [AW-1:0] mq[$];
    bit            m_ack = 0;
    bit            m_active = 0;
    int            m_left = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // one clock cycle: drive at falling edge, compare, advance model at rising edge
    task automatic cyc(input bit iv, input logic [AW-1:0] ia, input bit gr,
                       input bit rq, input bit mv, input logic [AW-1:0] ma);
        bit ready_e, push_e, civ_e, pop_e, hold_e, roa, done_e, stall_e;
        int rem;
        string btag;
        @(negedge clk);
        inv_valid = iv; inv_addr = ia; cache_inv_grant = gr;
        rb_req = rq; msg_valid = mv; msg_addr = ma;
        #1;
        ready_e = (mq.size() < QD);
        push_e  = iv && ready_e;
        civ_e   = (mq.size() > 0);
        pop_e   = civ_e && gr;
        hold_e  = 0;
        if (mv) foreach (mq[k]) if (mq[k] == ma) hold_e = 1;
        rem     = m_active ? m_left : mq.size();
        roa     = rq || m_active;
        done_e  = roa && (rem - int'(pop_e) == 0);
        stall_e = roa && !done_e;
        if (rq && !m_active && mq.size() == 0) btag = "R7";
        else if (rq && m_active)               btag = "R10";
        else if (m_active && push_e)           btag = "R9";
        else                                   btag = "R8";

        chk((push_e && pop_e) ? "R11" : (mq.size() == QD ? "R3" : "R2"), "inv_ready", inv_ready, ready_e);
        chk("R2", "inv_ack", inv_ack, m_ack);
        chk("R4", "cache_inv_valid", cache_inv_valid, civ_e);
        if (civ_e) chk(gr ? "R4" : "R5", "cache_inv_addr", cache_inv_addr, mq[0]);
        chk("R6", "msg_hold", msg_hold, hold_e);
        chk(btag, "rb_done", rb_done, done_e);
        chk(btag, "rb_stall", rb_stall, stall_e);

        @(posedge clk);
        m_ack = push_e;
        if (pop_e) void'(mq.pop_front());
        if (push_e) mq.push_back(ia);
        m_active = stall_e;
        m_left   = stall_e ? rem - int'(pop_e) : 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "reset inv_ready", inv_ready, 1);
        chk("R1", "reset inv_ack", inv_ack, 0);
        chk("R1", "reset cache_inv_valid", cache_inv_valid, 0);
        chk("R1", "reset msg_hold", msg_hold, 0);
        chk("R1", "reset rb_stall", rb_stall, 0);
        chk("R1", "reset rb_done", rb_done, 0);

        // R7 barrier on empty queue
        cyc(0, '0, 0, 1, 0, '0);
        idle(1);

        // R2/R4/R6 queue five lines without grant, probe hits and misses
        for (int i = 0; i < 5; i++) cyc(1, AW'(26'h100 + i), 0, 0, 1, AW'(26'h102));
        cyc(0, '0, 0, 0, 1, AW'(26'h104));
        cyc(0, '0, 0, 0, 1, AW'(26'h1ff));
        cyc(0, '0, 0, 0, 0, AW'(26'h100));

        // R3 fill and push while full
        for (int i = 0; i < 4; i++) cyc(1, AW'(26'h200 + i), 0, 0, 0, '0);
        cyc(1, AW'(26'h3ff), 0, 0, 1, AW'(26'h3ff));
        idle(1);

        // R8/R9/R10 barrier with arrivals and repeated requests during drain
        cyc(0, '0, 1, 1, 0, '0);
        cyc(1, AW'(26'h300), 1, 1, 0, '0);
        for (int i = 0; i < 8; i++) cyc(i % 2 == 0, AW'(26'h310 + i), i % 3 != 2, i == 4, 1, AW'(26'h200));
        idle(2);

        // R11 simultaneous insert and remove
        for (int i = 0; i < 12; i++) cyc(1, AW'(26'h400 + i), 1, 0, 1, AW'(26'h405));
        for (int i = 0; i < 10; i++) cyc(0, '0, 1, 0, 0, '0);

        // random traffic with narrow address range
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) != 0, AW'($urandom % 12), ($urandom % 3) == 0,
                ($urandom % 9) == 0, ($urandom % 2) == 0, AW'($urandom % 12));
        end
        for (int i = 0; i < 12; i++) cyc(0, '0, 1, 0, 0, '0);
        finish_run();
    end

endmodule